// File: doc/BRIEF.md
# Master Video Timing Generator

This block is the free-running timing source of a video encoder. From the pixel clock it counts positions within a line and half-lines within a field. From those counts it drives two reference pins.

The first pin can carry one of three signals, chosen by a select input:
- a vertical sync pulse,
- an odd/even field flag,
- a flag marking the first field of the colour field sequence.

The second pin carries a horizontal pulse. Its start and stop clock positions are programmable. It can be suppressed over a programmable range of lines, which turns it into a composite blanking signal.

The block supports 50 Hz and 60 Hz line lengths, interlaced and progressive fields, and a separate polarity and direction for each pin. It also flags when the burst-blanking sequence of the 50 Hz colour standard may run.

Time is counted in half-lines, so a field may end in the middle of a line. In interlaced operation, fields therefore alternate between starting at the line start and starting at mid-line. In progressive operation every field is one half-line shorter, so all fields hold the same whole number of lines.

Configuration inputs are expected to change only while reset is held.

Top module: `vtg_master_timing`

## Requirements
- R1: A line lasts LINE_50 clocks (default 1728) when `std_50hz` is 1 and LINE_60 clocks (default 1716) when it is 0. The horizontal position runs from 0 to the line length minus one, and a half-line boundary falls at positions 0 and half the line length.
- R2: An interlaced field lasts FIELD_HL_50 half-lines (default 625) at 50 Hz and FIELD_HL_60 half-lines (default 525) at 60 Hz. A progressive field is one half-line shorter. The first field after reset starts at horizontal position 0.
- R3: With `rcv1_sel` = 2'b00 or 2'b11, pin 1 is active for the first VS_HL_50 half-lines (default 5) of each field at 50 Hz, or the first VS_HL_60 half-lines (default 6) at 60 Hz.
- R4: With `rcv1_sel` = 2'b01, pin 1 is the odd/even flag: inactive in odd fields and active in even fields. Fields alternate when interlaced, and the first field after reset is odd. In progressive operation the flag stays inactive.
- R5: With `rcv1_sel` = 2'b10, pin 1 is active for the whole of field 0 of a field cycle. The cycle is 4 fields at 60 Hz, 8 fields at 50 Hz with `secam_seq` = 0, and 12 fields at 50 Hz with `secam_seq` = 1. The cycle restarts at reset.
- R6: When `hpulse_start` < `hpulse_stop`, pin 2 is active at horizontal positions p with start <= p < stop. When the two values are equal, pin 2 is never active.
- R7: When `hpulse_start` > `hpulse_stop`, pin 2 is active at p >= start or p < stop, so the pulse wraps across the end of the line.
- R8: When `cblank_en` is 1, pin 2 is held inactive on every line whose index is from `cblank_first` to `cblank_last` inclusive. The line index is the half-line index within the field divided by two, rounded down.
- R9: `burst_seq_on` is 1 only in interlaced 50 Hz operation with `secam_seq` = 0, and 0 otherwise.
- R10: An active level is 1 on a pin when its invert input is 0, and 0 when the invert input is 1. `rcv1_oe` and `rcv2_oe` follow `rcv1_dir` and `rcv2_dir` directly.
- R11: While `rst` is high, both pins sit at their inactive level and `burst_seq_on` is 0. After release, counting resumes from horizontal position 0, half-line 0, field 0, odd parity.
- R12: Pin values and `burst_seq_on` are registered. After the n-th clock edge out of reset, they show the timing state reached after n-1 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| std_50hz | input | 1 | 1 selects 50 Hz timing, 0 selects 60 Hz |
| secam_seq | input | 1 | At 50 Hz, selects the 12-field cycle instead of 8 |
| interlace | input | 1 | 1 interlaced, 0 progressive |
| rcv1_sel | input | 2 | Pin 1 source: 00/11 vsync, 01 odd/even, 10 field-sequence |
| rcv1_inv | input | 1 | Pin 1 polarity invert |
| rcv2_inv | input | 1 | Pin 2 polarity invert |
| rcv1_dir | input | 1 | Pin 1 output enable request |
| rcv2_dir | input | 1 | Pin 2 output enable request |
| hpulse_start | input | HW | Horizontal pulse first active position |
| hpulse_stop | input | HW | Horizontal pulse first inactive position |
| cblank_en | input | 1 | Enables line-range suppression of pin 2 |
| cblank_first | input | VW | First suppressed line index |
| cblank_last | input | VW | Last suppressed line index |
| rcv1_o | output | 1 | Reference pin 1 level |
| rcv2_o | output | 1 | Reference pin 2 level |
| rcv1_oe | output | 1 | Pin 1 drive enable |
| rcv2_oe | output | 1 | Pin 2 drive enable |
| burst_seq_on | output | 1 | Burst-blanking sequence permitted |

## Verification
A wrong horizontal count shows on pin 2 within one line, as a shifted or resized pulse. A wrong half-line or field count first shows at the next field boundary, as a misplaced vsync edge or an odd/even flag that fails to alternate. A wrong field-sequence count can stay hidden until a whole 4-, 8- or 12-field cycle has passed. The bench therefore runs every configuration for longer than one full sequence cycle and compares every pin on every clock against arithmetic computed from the clock count.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        REF_VSYNC     = 2'b00,
        REF_ODDEVEN   = 2'b01,
        REF_FSEQ      = 2'b10,
        REF_VSYNC_ALT = 2'b11
    } ref_sel_e;

    typedef enum logic {
        V_SYNC = 1'b0,
        V_BODY = 1'b1
    } vphase_e;

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
    parameter int LINE_50 = 1728,
    parameter int LINE_60 = 1716,
    parameter int HW      = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          std50,
    output logic [HW-1:0] h,
    output logic          half_tick
);

    logic [HW-1:0] line_m1;
    logic [HW-1:0] half_m1;
    logic          line_end;

    always_comb begin
        if (std50) begin
            line_m1 = HW'(LINE_50 - 1);
            half_m1 = HW'(LINE_50 / 2 - 1);
        end else begin
            line_m1 = HW'(LINE_60 - 1);
            half_m1 = HW'(LINE_60 / 2 - 1);
        end
    end

    assign line_end  = (h == line_m1);
    assign half_tick = line_end || (h == half_m1);

    always_ff @(posedge clk) begin
        if (rst || line_end) begin
            h <= '0;
        end else begin
            h <= h + 1'b1;
        end
    end

    // R1: position never passes the selected line end
    p_h_bound_r1: assert property (@(posedge clk) disable iff (rst)
        h <= line_m1);

    // R1: the last position of a line is followed by position 0
    p_line_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (h == '0));

endmodule

// File: rtl/vtg_field.sv
module vtg_field
    import vtg_pkg::*;
#(
    parameter int FIELD_HL_50 = 625,
    parameter int FIELD_HL_60 = 525,
    parameter int VS_HL_50    = 5,
    parameter int VS_HL_60    = 6,
    parameter int VW          = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          std50,
    input  logic          secam,
    input  logic          ilace,
    input  logic          half_tick,
    output logic [VW-1:0] hl,
    output logic          par,
    output logic          seq_first,
    output logic          vs
);

    logic [VW-1:0] fhl_m1;
    logic [VW-1:0] vs_m1;
    logic [3:0]    seq_m1;
    logic [3:0]    seq;
    logic          fend;
    vphase_e       vstate;
    vphase_e       vnext;

    always_comb begin
        if (std50) begin
            fhl_m1 = ilace ? VW'(FIELD_HL_50 - 1) : VW'(FIELD_HL_50 - 2);
            vs_m1  = VW'(VS_HL_50 - 1);
            seq_m1 = secam ? 4'd11 : 4'd7;
        end else begin
            fhl_m1 = ilace ? VW'(FIELD_HL_60 - 1) : VW'(FIELD_HL_60 - 2);
            vs_m1  = VW'(VS_HL_60 - 1);
            seq_m1 = 4'd3;
        end
    end

    assign fend = half_tick && (hl == fhl_m1);

    // half-line, parity and sequence counters
    always_ff @(posedge clk) begin
        if (rst) begin
            hl  <= '0;
            par <= 1'b0;
            seq <= '0;
        end else if (half_tick) begin
            if (fend) begin
                hl  <= '0;
                par <= ilace ? ~par : 1'b0;
                seq <= (seq == seq_m1) ? 4'd0 : seq + 4'd1;
            end else begin
                hl <= hl + 1'b1;
            end
        end
    end

    // vertical phase state register
    always_ff @(posedge clk) begin
        if (rst) begin
            vstate <= V_SYNC;
        end else begin
            vstate <= vnext;
        end
    end

    // vertical phase transitions
    always_comb begin
        vnext = vstate;
        unique case (vstate)
            V_SYNC: begin
                if (fend) begin
                    vnext = V_SYNC;
                end else if (half_tick && (hl == vs_m1)) begin
                    vnext = V_BODY;
                end
            end
            V_BODY: begin
                if (fend) begin
                    vnext = V_SYNC;
                end
            end
            default: vnext = V_SYNC;
        endcase
    end

    // outputs
    always_comb begin
        vs        = (vstate == V_SYNC);
        seq_first = (seq == 4'd0);
    end

    // R2: half-line index stays inside the field
    p_hl_bound_r2: assert property (@(posedge clk) disable iff (rst)
        hl <= fhl_m1);

    // R3: the sync phase covers exactly the leading half-lines
    p_vs_window_r3: assert property (@(posedge clk) disable iff (rst)
        (vstate == V_SYNC) == (hl <= vs_m1));

    // R4: a progressive field boundary leaves odd parity
    p_ni_odd_r4: assert property (@(posedge clk) disable iff (rst)
        (fend && !ilace) |=> !par);

    // R5: sequence index stays inside its cycle
    p_seq_bound_r5: assert property (@(posedge clk) disable iff (rst)
        seq <= seq_m1);

endmodule

// File: rtl/vtg_refout.sv
module vtg_refout
    import vtg_pkg::*;
#(
    parameter int HW = 11,
    parameter int VW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] hl,
    input  logic          par,
    input  logic          seq_first,
    input  logic          vs,
    input  logic          std50,
    input  logic          secam,
    input  logic          ilace,
    input  logic [1:0]    sel,
    input  logic [HW-1:0] hstart,
    input  logic [HW-1:0] hstop,
    input  logic          cb_en,
    input  logic [VW-1:0] cb_first,
    input  logic [VW-1:0] cb_last,
    output logic          r1_raw,
    output logic          r2_raw,
    output logic          burst_q
);

    logic          in_pulse;
    logic          blanked;
    logic [VW-1:0] line_idx;
    logic          r1_next;

    always_comb begin
        if (hstart < hstop) begin
            in_pulse = (h >= hstart) && (h < hstop);
        end else if (hstart > hstop) begin
            in_pulse = (h >= hstart) || (h < hstop);
        end else begin
            in_pulse = 1'b0;
        end
        line_idx = {1'b0, hl[VW-1:1]};
        blanked  = cb_en && (line_idx >= cb_first) && (line_idx <= cb_last);
    end

    always_comb begin
        unique case (ref_sel_e'(sel))
            REF_VSYNC, REF_VSYNC_ALT: r1_next = vs;
            REF_ODDEVEN:              r1_next = ilace && par;
            REF_FSEQ:                 r1_next = seq_first;
            default:                  r1_next = vs;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r1_raw  <= 1'b0;
            r2_raw  <= 1'b0;
            burst_q <= 1'b0;
        end else begin
            r1_raw  <= r1_next;
            r2_raw  <= in_pulse && !blanked;
            burst_q <= ilace && std50 && !secam;
        end
    end

    // R8: a suppressed line yields an inactive pulse one cycle later
    p_cblank_r8: assert property (@(posedge clk) disable iff (rst)
        blanked |=> !r2_raw);

    // R9: progressive operation never enables the burst sequence
    p_burst_ni_r9: assert property (@(posedge clk) disable iff (rst)
        !ilace |=> !burst_q);

    // R6: equal start and stop produce no pulse
    p_empty_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        (hstart == hstop) |=> !r2_raw);

endmodule

// File: rtl/vtg_master_timing.sv
module vtg_master_timing #(
    parameter int LINE_50     = 1728,
    parameter int LINE_60     = 1716,
    parameter int FIELD_HL_50 = 625,
    parameter int FIELD_HL_60 = 525,
    parameter int VS_HL_50    = 5,
    parameter int VS_HL_60    = 6,
    localparam int HW = $clog2((LINE_50 > LINE_60) ? LINE_50 : LINE_60),
    localparam int VW = $clog2((FIELD_HL_50 > FIELD_HL_60) ? FIELD_HL_50 : FIELD_HL_60)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          std_50hz,
    input  logic          secam_seq,
    input  logic          interlace,
    input  logic [1:0]    rcv1_sel,
    input  logic          rcv1_inv,
    input  logic          rcv2_inv,
    input  logic          rcv1_dir,
    input  logic          rcv2_dir,
    input  logic [HW-1:0] hpulse_start,
    input  logic [HW-1:0] hpulse_stop,
    input  logic          cblank_en,
    input  logic [VW-1:0] cblank_first,
    input  logic [VW-1:0] cblank_last,
    output logic          rcv1_o,
    output logic          rcv2_o,
    output logic          rcv1_oe,
    output logic          rcv2_oe,
    output logic          burst_seq_on
);

    logic [HW-1:0] h;
    logic          half_tick;
    logic [VW-1:0] hl;
    logic          par;
    logic          seq_first;
    logic          vs;
    logic          r1_raw;
    logic          r2_raw;

    vtg_hcount #(
        .LINE_50 (LINE_50),
        .LINE_60 (LINE_60),
        .HW      (HW)
    ) u_hcount (
        .clk       (clk),
        .rst       (rst),
        .std50     (std_50hz),
        .h         (h),
        .half_tick (half_tick)
    );

    vtg_field #(
        .FIELD_HL_50 (FIELD_HL_50),
        .FIELD_HL_60 (FIELD_HL_60),
        .VS_HL_50    (VS_HL_50),
        .VS_HL_60    (VS_HL_60),
        .VW          (VW)
    ) u_field (
        .clk       (clk),
        .rst       (rst),
        .std50     (std_50hz),
        .secam     (secam_seq),
        .ilace     (interlace),
        .half_tick (half_tick),
        .hl        (hl),
        .par       (par),
        .seq_first (seq_first),
        .vs        (vs)
    );

    vtg_refout #(
        .HW (HW),
        .VW (VW)
    ) u_refout (
        .clk       (clk),
        .rst       (rst),
        .h         (h),
        .hl        (hl),
        .par       (par),
        .seq_first (seq_first),
        .vs        (vs),
        .std50     (std_50hz),
        .secam     (secam_seq),
        .ilace     (interlace),
        .sel       (rcv1_sel),
        .hstart    (hpulse_start),
        .hstop     (hpulse_stop),
        .cb_en     (cblank_en),
        .cb_first  (cblank_first),
        .cb_last   (cblank_last),
        .r1_raw    (r1_raw),
        .r2_raw    (r2_raw),
        .burst_q   (burst_seq_on)
    );

    assign rcv1_o  = r1_raw ^ rcv1_inv;
    assign rcv2_o  = r2_raw ^ rcv2_inv;
    assign rcv1_oe = rcv1_dir;
    assign rcv2_oe = rcv2_dir;

    // R11: the first cycle after reset release still shows inactive pins
    p_reset_idle_r11: assert property (@(posedge clk)
        $fell(rst) |-> (r1_raw == 1'b0) && (r2_raw == 1'b0) && !burst_seq_on);

endmodule

// File: tb/vtg_master_timing_tb.sv
module vtg_master_timing_tb;

    localparam int L50 = 16;
    localparam int L60 = 12;
    localparam int F50 = 11;
    localparam int F60 = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       std_50hz = 1'b0;
    logic       secam_seq = 1'b0;
    logic       interlace = 1'b0;
    logic [1:0] rcv1_sel = 2'b00;
    logic       rcv1_inv = 1'b0;
    logic       rcv2_inv = 1'b0;
    logic       rcv1_dir = 1'b0;
    logic       rcv2_dir = 1'b0;
    logic [3:0] hpulse_start = 4'd0;
    logic [3:0] hpulse_stop = 4'd0;
    logic       cblank_en = 1'b0;
    logic [3:0] cblank_first = 4'd0;
    logic [3:0] cblank_last = 4'd0;
    logic       rcv1_o;
    logic       rcv2_o;
    logic       rcv1_oe;
    logic       rcv2_oe;
    logic       burst_seq_on;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vtg_master_timing #(
        .LINE_50     (L50),
        .LINE_60     (L60),
        .FIELD_HL_50 (F50),
        .FIELD_HL_60 (F60),
        .VS_HL_50    (5),
        .VS_HL_60    (6)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .std_50hz     (std_50hz),
        .secam_seq    (secam_seq),
        .interlace    (interlace),
        .rcv1_sel     (rcv1_sel),
        .rcv1_inv     (rcv1_inv),
        .rcv2_inv     (rcv2_inv),
        .rcv1_dir     (rcv1_dir),
        .rcv2_dir     (rcv2_dir),
        .hpulse_start (hpulse_start),
        .hpulse_stop  (hpulse_stop),
        .cblank_en    (cblank_en),
        .cblank_first (cblank_first),
        .cblank_last  (cblank_last),
        .rcv1_o       (rcv1_o),
        .rcv2_o       (rcv2_o),
        .rcv1_oe      (rcv1_oe),
        .rcv2_oe      (rcv2_oe),
        .burst_seq_on (burst_seq_on)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    // expected raw levels after n edges of state, from requirement arithmetic
    task automatic expect_state(input int n, output logic e1, output logic e2);
        int len, half, fhl, seqlen, vsh, h, hc, hl, fld, ln, st, sp;
        logic par, vsx, fsx, hp;
        len    = std_50hz ? L50 : L60;                             // R1
        half   = len / 2;
        fhl    = (std_50hz ? F50 : F60) - (interlace ? 0 : 1);    // R2
        seqlen = std_50hz ? (secam_seq ? 12 : 8) : 4;             // R5
        vsh    = std_50hz ? 5 : 6;                                 // R3
        h      = n % len;
        hc     = n / half;
        hl     = hc % fhl;
        fld    = hc / fhl;
        par    = interlace ? logic'(fld % 2) : 1'b0;              // R4
        vsx    = (hl < vsh);
        fsx    = ((fld % seqlen) == 0);
        case (rcv1_sel)
            2'b01:   e1 = par;
            2'b10:   e1 = fsx;
            default: e1 = vsx;
        endcase
        st = int'(hpulse_start);
        sp = int'(hpulse_stop);
        if (st < sp)      hp = (h >= st) && (h < sp);            // R6
        else if (st > sp) hp = (h >= st) || (h < sp);            // R7
        else              hp = 1'b0;
        ln = hl / 2;
        if (cblank_en && ln >= int'(cblank_first) && ln <= int'(cblank_last))
            hp = 1'b0;                                             // R8
        e2 = hp;
    endtask

    task automatic run_config(input int ncyc);
        logic e1, e2;
        string t1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state, R10 polarity at inactive level
        check("R11 R10 rcv1 in reset", rcv1_o, rcv1_inv);
        check("R11 R10 rcv2 in reset", rcv2_o, rcv2_inv);
        check("R11 burst in reset", burst_seq_on, 1'b0);
        check("R10 rcv1 direction", rcv1_oe, rcv1_dir);
        check("R10 rcv2 direction", rcv2_oe, rcv2_dir);
        t1 = (rcv1_sel == 2'b01) ? "R4 R2 R12 rcv1 odd/even" :
             (rcv1_sel == 2'b10) ? "R5 R2 R12 rcv1 field-seq" : "R3 R2 R12 rcv1 vsync";
        rst = 1'b0;
        for (int n = 1; n <= ncyc; n++) begin
            @(posedge clk);
            @(negedge clk);
            expect_state(n - 1, e1, e2);
            check(t1, rcv1_o, e1 ^ rcv1_inv);
            check("R1 R6 R7 R8 R10 R12 rcv2 pulse", rcv2_o, e2 ^ rcv2_inv);
            check("R9 burst sequence flag", burst_seq_on,
                  interlace && std_50hz && !secam_seq);
        end
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 2; c++) begin
                for (int il = 0; il < 2; il++) begin
                    for (int sl = 0; sl < 3; sl++) begin
                        int len, fhl, seqlen;
                        rst = 1'b1;
                        std_50hz  = logic'(s);
                        secam_seq = logic'(c);
                        interlace = logic'(il);
                        rcv1_sel  = 2'(sl);
                        rcv1_inv  = logic'(sl % 2);
                        rcv2_inv  = logic'(il);
                        rcv1_dir  = logic'(c);
                        rcv2_dir  = logic'(1 - il);
                        case (sl)
                            0: begin hpulse_start = 4'd3;  hpulse_stop = 4'd7;
                                     cblank_en = 1'b1; cblank_first = 4'd2; cblank_last = 4'd3; end
                            1: begin hpulse_start = 4'd10; hpulse_stop = 4'd2;
                                     cblank_en = 1'b1; cblank_first = 4'd1; cblank_last = 4'd1; end
                            default: begin hpulse_start = 4'd5; hpulse_stop = 4'd5;
                                     cblank_en = 1'b0; cblank_first = 4'd0; cblank_last = 4'd4; end
                        endcase
                        len    = s ? L50 : L60;
                        fhl    = (s ? F50 : F60) - (il ? 0 : 1);
                        seqlen = s ? (c ? 12 : 8) : 4;
                        run_config(seqlen * fhl * (len / 2) + 3 * len * fhl);
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule